// File: doc/BRIEF.md
# Serial FIFO Threshold Flag Unit

This block sits between a CPU register bus and the byte serializer of a serial port. It holds two byte queues of 16 entries each. The CPU fills the transmit queue and the serializer drains it. The serializer fills the receive queue and the CPU drains it. The block keeps a fill count for each queue. A count register shows both counts together. Each direction has its own 2-bit threshold select.

There are two service flags. The transmit flag asks the CPU for more data when the transmit queue has run low. The receive flag asks the CPU to collect data when enough bytes are waiting. Both flags are level-sticky. Once set, a flag stays set until the CPU performs a clear handshake: it reads the flag as 1, then writes 0 to it. A clear done while the queue still meets its threshold takes effect for one cycle, and the flag sets again on the next cycle. Software must therefore move the queue past the threshold before it clears the flag.

Register map, with the 3-bit address shown in brackets:
- TXQ [0]: a write pushes a byte.
- RXQ [1]: a read pops a byte.
- FLAGS [2]: bit 0 is the transmit flag and bit 1 is the receive flag.
- CTRL [3]: bits 1:0 select the transmit threshold, bits 3:2 select the receive threshold, bit 4 flushes the transmit queue and bit 5 flushes the receive queue.
- LEVELS [4]: read-only. Bits 15:8 hold the transmit count and bits 7:0 hold the receive count.

Top module: `sfifo_trigger_stat`

## Requirements
- R1: A bus write to address 0 pushes `reg_wdata` into the transmit queue. A push into a full queue (16 bytes) is dropped, and the count stays at 16.
- R2: `rx_push` stores `rx_byte` in the receive queue. A bus read of address 1 returns the oldest byte and removes it. A read while the queue is empty returns the byte returned by the last successful read, and the count stays at 0.
- R3: A read of address 4 returns the transmit count in bits 15:8 and the receive count in bits 7:0.
- R4: Transmit threshold codes 00/01/10/11 mean 8/4/2/1 bytes. The transmit flag (FLAGS bit 0) sets one cycle after the transmit count is at or below the selected level.
- R5: Receive threshold codes 00/01/10/11 mean 1/4/8/14 bytes. The receive flag (FLAGS bit 1) sets one cycle after the receive count is at or above the selected level.
- R6: A flag clears only when a write of 0 to its FLAGS bit follows a FLAGS read that returned that bit as 1. Writing 1 has no effect on the flag. Writing 0 without that prior read also has no effect.
- R7: If a flag is cleared while its threshold condition still holds, it reads 0 for one cycle and then sets again. If the condition no longer holds, the flag stays 0.
- R8: Writing CTRL with bit 4 set empties the transmit queue. Writing CTRL with bit 5 set empties the receive queue. Both counts go to 0.
- R9: Reset clears both counts, both flags and both threshold selects. A read of CTRL returns the selects in bits 3:0.
- R10: `tx_byte` shows the oldest transmit byte, and `tx_pop` removes it. Bytes leave in the order they were written. `tx_pop` on an empty queue is ignored, and `tx_nonempty` is 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of RXQ pops a byte) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| tx_pop | input | 1 | Serializer takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_nonempty | output | 1 | Transmit queue holds at least one byte |
| rx_push | input | 1 | Serializer delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_flag | output | 1 | Transmit service flag |
| rx_flag | output | 1 | Receive service flag |

## Verification
The bench clears each flag too early and checks that it drops for exactly one cycle and then returns. A design that ignored the clear would never show the drop. A design that gated the set with the clear would lose the flag for good. The bench also writes 1, and writes 0 without the arming read, to show that neither clears the flag. A flag that cleared on any write would fail those checks. The bench checks every threshold edge in both directions: one byte off the level keeps the flag low, and exactly at the level sets it. This catches a strict comparison used where an inclusive one is needed. Finally, the bench overfills the transmit queue, over-reads the empty receive queue and flushes both queues. A design that wrapped its pointers or counts would return bytes in the wrong order, report a wrong count, or fail to return the last byte read.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam logic [2:0] A_TXQ    = 3'd0;
    localparam logic [2:0] A_RXQ    = 3'd1;
    localparam logic [2:0] A_FLAGS  = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_LEVELS = 3'd4;

    // Transmit threshold: flag when count <= level.
    function automatic logic [7:0] tx_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8'd8;
            2'b01:   return 8'd4;
            2'b10:   return 8'd2;
            default: return 8'd1;
        endcase
    endfunction

    // Receive threshold: flag when count >= level.
    function automatic logic [7:0] rx_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8'd1;
            2'b01:   return 8'd4;
            2'b10:   return 8'd8;
            default: return 8'd14;
        endcase
    endfunction
endpackage

// File: rtl/sfifo_byte_queue.sv
module sfifo_byte_queue #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !flush && count == CW'(DEPTH) |=> count == CW'(DEPTH)); // R1
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && !flush && count == '0 |=> count == '0); // R10
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0); // R8
endmodule

// File: rtl/sfifo_sticky_flag.sv
module sfifo_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic rd_flags,
    input  logic wr_flags,
    input  logic wr_bit,
    output logic flag
);
    typedef struct packed {
        logic flag;
        logic armed;
    } f_state_t;

    f_state_t st_d, st_q;
    logic     clr;

    always_comb begin
        st_d = st_q;
        clr  = wr_flags && !wr_bit && st_q.armed;
        if (clr) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end else begin
            st_d.flag = st_q.flag | cond;
            if (rd_flags && st_q.flag) st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(wr_flags && !wr_bit) |=> flag); // R6
    AST_WR1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        flag && wr_flags && wr_bit |=> flag); // R6
    AST_SET_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && cond |=> flag); // R4
    AST_COMES_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) && cond && !wr_flags |=> flag); // R7
endmodule

// File: rtl/sfifo_trigger_stat.sv
module sfifo_trigger_stat #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int RW    = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int FW   = RW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_byte,
    output logic          tx_nonempty,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_byte,
    output logic          tx_flag,
    output logic          rx_flag
);
    import sfifo_pkg::*;

    typedef struct packed {
        logic [1:0]    tx_sel;
        logic [1:0]    rx_sel;
        logic [DW-1:0] rx_last;
    } t_state_t;

    t_state_t      st_d, st_q;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DW-1:0] rx_head;
    logic          wr_ctrl, wr_flags, rd_flags, tx_push, rx_pop;
    logic          tx_cond, rx_cond;

    assign tx_push  = reg_wr && reg_addr == A_TXQ;
    assign rx_pop   = reg_rd && reg_addr == A_RXQ;
    assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
    assign wr_flags = reg_wr && reg_addr == A_FLAGS;
    assign rd_flags = reg_rd && reg_addr == A_FLAGS;

    sfifo_byte_queue #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata),
        .pop(tx_pop), .flush(wr_ctrl && reg_wdata[4]),
        .dout(tx_byte), .count(tx_cnt));

    sfifo_byte_queue #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .flush(wr_ctrl && reg_wdata[5]),
        .dout(rx_head), .count(rx_cnt));

    assign tx_cond = FW'(tx_cnt) <= FW'(tx_level(st_q.tx_sel));
    assign rx_cond = FW'(rx_cnt) >= FW'(rx_level(st_q.rx_sel));

    sfifo_sticky_flag u_txf (
        .clk(clk), .rst_n(rst_n), .cond(tx_cond), .rd_flags(rd_flags),
        .wr_flags(wr_flags), .wr_bit(reg_wdata[0]), .flag(tx_flag));

    sfifo_sticky_flag u_rxf (
        .clk(clk), .rst_n(rst_n), .cond(rx_cond), .rd_flags(rd_flags),
        .wr_flags(wr_flags), .wr_bit(reg_wdata[1]), .flag(rx_flag));

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.tx_sel = reg_wdata[1:0];
            st_d.rx_sel = reg_wdata[3:2];
        end
        if (rx_pop && rx_cnt != '0) st_d.rx_last = rx_head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXQ:    reg_rdata = RW'((rx_cnt == '0) ? st_q.rx_last : rx_head);
            A_FLAGS:  reg_rdata = RW'({rx_flag, tx_flag});
            A_CTRL:   reg_rdata = RW'({st_q.rx_sel, st_q.tx_sel});
            A_LEVELS: reg_rdata = {FW'(tx_cnt), FW'(rx_cnt)};
            default:  reg_rdata = '0;
        endcase
    end

    assign tx_nonempty = tx_cnt != '0;

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && !rx_push && rx_cnt == '0 |=> rx_cnt == '0 && $stable(st_q.rx_last)); // R2
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(st_q.tx_sel) && $stable(st_q.rx_sel)); // R9
endmodule

// File: tb/sfifo_trigger_stat_tb.sv
module sfifo_trigger_stat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0, rx_byte = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  tx_byte;
    logic        tx_nonempty, tx_flag, rx_flag;
    int          n_run = 0, n_fail = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    sfifo_trigger_stat u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_nonempty(tx_nonempty),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_flag(tx_flag), .rx_flag(rx_flag));

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic txpop();
        tx_pop = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic rxpush(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b;
        @(posedge clk); @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        idle(2);
        check("R9 tx_flag in reset", 16'(tx_flag), 16'h0);
        check("R9 rx_flag in reset", 16'(rx_flag), 16'h0);
        reg_addr = 3'd4; #1 check("R9 levels in reset", reg_rdata, 16'h0000);
        rst_n = 1'b1;
        idle(2);
        check("R4 tx flag after reset", 16'(tx_flag), 16'h1);
        check("R5 rx flag idle", 16'(rx_flag), 16'h0);
        rd(3'd3, v); check("R9 ctrl reset", v, 16'h0000);
    endtask

    task automatic t_clear_seq();
        logic [15:0] v;
        for (int i = 0; i < 9; i++) wr(3'd0, 8'h10 + 8'(i));
        idle(2);
        check("R6 sticky above level", 16'(tx_flag), 16'h1);
        rd(3'd4, v); check("R3 levels tx=9", v, 16'h0900);
        wr(3'd2, 8'h00); idle(1);
        check("R6 write0 without read", 16'(tx_flag), 16'h1);
        rd(3'd2, v); check("R6 flags read", v, 16'h0001);
        wr(3'd2, 8'h03); idle(1);
        check("R6 write1 no effect", 16'(tx_flag), 16'h1);
        wr(3'd2, 8'h02);
        check("R6 cleared", 16'(tx_flag), 16'h0);
        idle(2);
        check("R7 stays clear above level", 16'(tx_flag), 16'h0);
        check("R10 head byte", 16'(tx_byte), 16'h0010);
        txpop(); idle(1);
        check("R4 sets at level 8", 16'(tx_flag), 16'h1);
    endtask

    task automatic t_premature();
        logic [15:0] v;
        wr(3'd3, 8'h10);
        for (int i = 0; i < 3; i++) wr(3'd0, 8'(i));
        rd(3'd2, v);
        wr(3'd2, 8'h02);
        check("R7 drops for one cycle", 16'(tx_flag), 16'h0);
        idle(1);
        check("R7 returns", 16'(tx_flag), 16'h1);
    endtask

    task automatic t_tx_levels();
        logic [15:0] v;
        wr(3'd3, 8'h13);
        for (int i = 0; i < 2; i++) wr(3'd0, 8'(i));
        rd(3'd2, v); wr(3'd2, 8'h02); idle(2);
        check("R4 level1 count2 clear", 16'(tx_flag), 16'h0);
        txpop(); idle(1);
        check("R4 level1 count1 set", 16'(tx_flag), 16'h1);
        wr(3'd3, 8'h11);
        for (int i = 0; i < 5; i++) wr(3'd0, 8'(i));
        rd(3'd2, v); wr(3'd2, 8'h02); idle(2);
        check("R4 level4 count5 clear", 16'(tx_flag), 16'h0);
        txpop(); idle(1);
        check("R4 level4 count4 set", 16'(tx_flag), 16'h1);
        wr(3'd3, 8'h12);
        for (int i = 0; i < 3; i++) wr(3'd0, 8'(i));
        rd(3'd2, v); wr(3'd2, 8'h02); idle(2);
        check("R4 level2 count3 clear", 16'(tx_flag), 16'h0);
        txpop(); idle(1);
        check("R4 level2 count2 set", 16'(tx_flag), 16'h1);
    endtask

    task automatic t_tx_full();
        logic [15:0] v;
        int bad = 0;
        wr(3'd3, 8'h10);
        for (int i = 0; i < 17; i++) wr(3'd0, 8'hA0 + 8'(i));
        rd(3'd4, v); check("R1 full count 16", v, 16'h1000);
        for (int i = 0; i < 16; i++) begin
            if (tx_byte !== 8'hA0 + 8'(i) || !tx_nonempty) bad++;
            txpop();
        end
        check("R10 order of 16 bytes", 16'(bad), 16'h0);
        check("R10 nonempty low", 16'(tx_nonempty), 16'h0);
        txpop();
        rd(3'd4, v); check("R10 pop on empty", v, 16'h0000);
    endtask

    task automatic t_rx();
        logic [15:0] v;
        int bad = 0;
        wr(3'd3, 8'h24);
        for (int i = 0; i < 3; i++) rxpush(8'h30 + 8'(i));
        idle(2);
        check("R5 level4 count3", 16'(rx_flag), 16'h0);
        rxpush(8'h33); idle(1);
        check("R5 level4 count4", 16'(rx_flag), 16'h1);
        rd(3'd4, v); check("R3 levels rx=4", v, 16'h0004);
        rxpush(8'h34); rxpush(8'h35);
        rd(3'd2, v); check("R6 flags both", v, 16'h0003);
        rd(3'd1, v); check("R2 first byte", v, 16'h0030);
        wr(3'd2, 8'h01);
        check("R7 rx drops", 16'(rx_flag), 16'h0);
        idle(1);
        check("R7 rx returns", 16'(rx_flag), 16'h1);
        for (int i = 1; i < 6; i++) begin
            rd(3'd1, v);
            if (v !== 16'h0030 + 16'(i)) bad++;
        end
        check("R2 byte order", 16'(bad), 16'h0);
        rd(3'd2, v); wr(3'd2, 8'h01); idle(2);
        check("R7 rx stays clear", 16'(rx_flag), 16'h0);
        rd(3'd1, v); check("R2 empty read last", v, 16'h0035);
        rd(3'd4, v); check("R2 empty count", v, 16'h0000);
    endtask

    task automatic t_rx_levels();
        logic [15:0] v;
        wr(3'd3, 8'h2C);
        for (int i = 0; i < 13; i++) rxpush(8'(i));
        idle(2);
        check("R5 level14 count13", 16'(rx_flag), 16'h0);
        rxpush(8'hEE); idle(1);
        check("R5 level14 count14", 16'(rx_flag), 16'h1);
        rd(3'd3, v); check("R9 ctrl readback", v, 16'h000C);
        wr(3'd3, 8'h28);
        rd(3'd4, v); check("R8 rx flush", v, 16'h0000);
        rd(3'd2, v); wr(3'd2, 8'h01); idle(2);
        for (int i = 0; i < 7; i++) rxpush(8'(i));
        idle(2);
        check("R5 level8 count7", 16'(rx_flag), 16'h0);
        rxpush(8'h77); idle(1);
        check("R5 level8 count8", 16'(rx_flag), 16'h1);
        for (int i = 0; i < 4; i++) wr(3'd0, 8'(i));
        wr(3'd3, 8'h30);
        rd(3'd4, v); check("R8 both flush", v, 16'h0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_clear_seq();
        t_premature();
        t_tx_levels();
        t_tx_full();
        t_rx();
        t_rx_levels();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule